// File: doc/BRIEF.md
# Packet Header/Data CRC Inserter

This stage sits on the transmit path, between a packet source and a byte-wide link transmitter. A packet comes in as one command word and two byte streams. The command word carries the header length, the data length and per-packet option bits. The header segment and the data segment then arrive on their own valid/ready channels. The stage sends the header bytes and then the data bytes to one output stream. Each segment can have an 8-bit CRC byte appended after it, and each of the two CRCs is enabled on its own. The header CRC can leave out a programmable number of leading header bytes, from 0 to 15.

The output stream marks the final byte of each packet. One cycle after that byte is taken, the stage gives a one-cycle completion status. The status reports either that the packet was transmitted or that a link error was seen while the packet was in flight. If the packet asked for it, an interrupt pulse is raised in the same cycle as the status. Header and data bytes go straight through to the output with no added latency. The stage only adds cycles where it emits its own CRC bytes and the one status cycle.

Top module: `pkt_crc_inserter`

## Requirements
- R1: Header bytes leave on the output unchanged and in arrival order, and all of them go out before any data byte. Data bytes also leave unchanged and in order.
- R2: When the header-CRC option is set and the header length is non-zero, exactly one CRC byte follows the last header byte. The CRC starts at 0x00. For each covered byte the CRC is XORed with the byte, then shifted right eight times; after each shift the value is XORed with 0xE0 if the bit shifted out was 1. This is x^8+x^2+x+1 processed least significant bit first.
- R3: The 4-bit skip count in the command leaves that many leading header bytes out of the header CRC. A skip count equal to or larger than the header length gives a header CRC of 0x00.
- R4: When the data-CRC option is set and the data length is non-zero, one CRC byte follows the last data byte. This CRC is computed by the same rule as R2 over all data bytes and restarts from 0x00.
- R5: A segment of length zero produces no bytes and no CRC byte, even when its CRC option is set. A packet with both lengths zero produces no output bytes and still completes with a status.
- R6: out_last is high on exactly one byte per packet, the final one. That byte is the data CRC, or else the last data byte, or else the header CRC, or else the last header byte.
- R7: Exactly one cycle after the final byte is accepted (or after a command with no output bytes), sts_valid is high for one cycle. If link_err was high in any cycle while the packet's bytes were being sent, the status reads sts_sent=0 and sts_link_err=1; otherwise it reads sts_sent=1 and sts_link_err=0. link_err while idle has no effect.
- R8: irq_pulse is high together with sts_valid only when the packet's interrupt option was set.
- R9: A command is accepted only while idle, and cmd_ready stays low until the status cycle has passed. An output byte held back by out_ready low stays valid and unchanged.
- R10: After reset the stage is idle: cmd_ready=1, and out_valid, hdr_ready, dat_ready, sts_valid and irq_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Packet command offered |
| cmd_ready | output | 1 | Command accepted (idle) |
| cmd_hdr_len | input | HLEN_W | Header length in bytes |
| cmd_dat_len | input | DLEN_W | Data length in bytes |
| cmd_hcrc_en | input | 1 | Append header CRC |
| cmd_dcrc_en | input | 1 | Append data CRC |
| cmd_skip | input | SKIP_W | Leading header bytes left out of header CRC |
| cmd_irq_en | input | 1 | Request interrupt pulse at completion |
| hdr_valid | input | 1 | Header byte offered |
| hdr_ready | output | 1 | Header byte taken |
| hdr_byte | input | 8 | Header byte |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte taken |
| dat_byte | input | 8 | Data byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Transmitter accepts byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of packet |
| link_err | input | 1 | Link error indication from transmitter |
| sts_valid | output | 1 | Completion status strobe |
| sts_sent | output | 1 | Packet transmitted without link error |
| sts_link_err | output | 1 | Link error seen during packet |
| irq_pulse | output | 1 | Completion interrupt pulse |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. A byte held back by out_ready low must stay stable. The status strobe lasts one cycle and never overlaps idle. The interrupt pulse only appears with the status. A status always follows the cycle after an accepted last byte. The two segment inputs are never ready at once. Other behaviour needs a full model of the expected packet, and only the bench scenarios can show it: CRC values, the effect of the skip count, where CRC bytes are placed or left out for empty segments, and how link errors are attributed. The bench sweeps header lengths, data lengths, both CRC options and several skip counts, with source gaps and output backpressure.

// File: rtl/pci_pkg.sv
// Package: shared types and the CRC byte step for the CRC inserter.
// Assumes byte-wide streams; the CRC polynomial is given in reflected form.
package pci_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CRC_POLY_REFL = 8'hE0;
    localparam logic [BYTE_W-1:0] CRC_INIT      = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_HCRC = 3'd2,
        ST_DAT  = 3'd3,
        ST_DCRC = 3'd4,
        ST_DONE = 3'd5
    } seq_state_t;

    // One byte through the LSB-first CRC.
    function automatic logic [BYTE_W-1:0] crc_byte_step(
        input logic [BYTE_W-1:0] crc_in,
        input logic [BYTE_W-1:0] data_in
    );
        logic [BYTE_W-1:0] c;
        c = crc_in ^ data_in;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/pci_crc8_acc.sv
// Module: CRC accumulator. Clears to the initial value on clr and folds in
// one byte per cycle when en is high. clr wins over en.
module pci_crc8_acc (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic [pci_pkg::BYTE_W-1:0] din,
    output logic [pci_pkg::BYTE_W-1:0] crc
);
    logic [pci_pkg::BYTE_W-1:0] crc_q;

    // Holds the running CRC of the current segment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= pci_pkg::CRC_INIT;
        else if (en)       crc_q <= pci_pkg::crc_byte_step(crc_q, din);
    end

    assign crc = crc_q;
endmodule

// File: rtl/pci_seg_counter.sv
// Module: segment byte counter. Counts accepted bytes of one segment and
// flags the final byte. Assumes len is non-zero whenever last is used.
module pci_seg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] len,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Byte index within the segment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_q + W'(1);
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == (len - W'(1)));
endmodule

// File: rtl/pci_status.sv
// Module: completion status. Records a link error seen while the packet is
// busy and reports it during the one-cycle done state.
module pci_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    input  logic done,
    input  logic link_err,
    input  logic irq_en,
    output logic sts_valid,
    output logic sts_sent,
    output logic sts_link_err,
    output logic irq_pulse
);
    logic err_q;

    // Sticky error flag, cleared when a new packet is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || start)     err_q <= 1'b0;
        else if (busy && link_err) err_q <= 1'b1;
    end

    assign sts_valid    = done;
    assign sts_sent     = done && !err_q;
    assign sts_link_err = done && err_q;
    assign irq_pulse    = done && irq_en;
endmodule

// File: rtl/pkt_crc_inserter.sv
// Module: header/data CRC inserter. Streams the header, an optional header
// CRC, the data and an optional data CRC, marks the last byte, then gives
// one status cycle. Assumes sources hold a byte stable while it is offered.
module pkt_crc_inserter #(
    parameter int HLEN_W = 8,
    parameter int DLEN_W = 16,
    parameter int SKIP_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [HLEN_W-1:0]          cmd_hdr_len,
    input  logic [DLEN_W-1:0]          cmd_dat_len,
    input  logic                       cmd_hcrc_en,
    input  logic                       cmd_dcrc_en,
    input  logic [SKIP_W-1:0]          cmd_skip,
    input  logic                       cmd_irq_en,
    input  logic                       hdr_valid,
    output logic                       hdr_ready,
    input  logic [pci_pkg::BYTE_W-1:0] hdr_byte,
    input  logic                       dat_valid,
    output logic                       dat_ready,
    input  logic [pci_pkg::BYTE_W-1:0] dat_byte,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [pci_pkg::BYTE_W-1:0] out_byte,
    output logic                       out_last,
    input  logic                       link_err,
    output logic                       sts_valid,
    output logic                       sts_sent,
    output logic                       sts_link_err,
    output logic                       irq_pulse
);
    import pci_pkg::*;

    seq_state_t st_q, st_d;

    logic [HLEN_W-1:0] hlen_q;
    logic [DLEN_W-1:0] dlen_q;
    logic [SKIP_W-1:0] skip_q;
    logic              hcrc_q, dcrc_q, irq_q;

    logic              cmd_fire, hdr_fire, dat_fire;
    logic [HLEN_W-1:0] hdr_cnt;
    logic [DLEN_W-1:0] dat_cnt;
    logic              hdr_last, dat_last;
    logic              crc_clr, crc_en;
    logic [BYTE_W-1:0] crc_val, crc_din;
    seq_state_t        first_st, after_hdr, after_hcrc, after_dat;

    assign cmd_ready = (st_q == ST_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign hdr_ready = (st_q == ST_HDR) && out_ready;
    assign dat_ready = (st_q == ST_DAT) && out_ready;
    assign hdr_fire  = hdr_valid && hdr_ready;
    assign dat_fire  = dat_valid && dat_ready;

    // Latches the per-packet command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hlen_q <= '0;
            dlen_q <= '0;
            skip_q <= '0;
            hcrc_q <= 1'b0;
            dcrc_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (cmd_fire) begin
            hlen_q <= cmd_hdr_len;
            dlen_q <= cmd_dat_len;
            skip_q <= cmd_skip;
            hcrc_q <= cmd_hcrc_en;
            dcrc_q <= cmd_dcrc_en;
            irq_q  <= cmd_irq_en;
        end
    end

    // Picks the segment that follows each phase, skipping empty ones.
    always_comb begin
        if (cmd_hdr_len != '0)      first_st = ST_HDR;
        else if (cmd_dat_len != '0) first_st = ST_DAT;
        else                        first_st = ST_DONE;
        after_hcrc = (dlen_q != '0) ? ST_DAT : ST_DONE;
        after_hdr  = hcrc_q ? ST_HCRC : after_hcrc;
        after_dat  = dcrc_q ? ST_DCRC : ST_DONE;
    end

    // Packet sequencer next state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (cmd_valid)             st_d = first_st;
            ST_HDR:  if (hdr_fire && hdr_last)  st_d = after_hdr;
            ST_HCRC: if (out_ready)             st_d = after_hcrc;
            ST_DAT:  if (dat_fire && dat_last)  st_d = after_dat;
            ST_DCRC: if (out_ready)             st_d = ST_DONE;
            ST_DONE:                            st_d = ST_IDLE;
            default:                            st_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    pci_seg_counter #(.W(HLEN_W)) u_hdr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .inc(hdr_fire),
        .len(hlen_q), .cnt(hdr_cnt), .last(hdr_last)
    );

    pci_seg_counter #(.W(DLEN_W)) u_dat_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .inc(dat_fire),
        .len(dlen_q), .cnt(dat_cnt), .last(dat_last)
    );

    // CRC restarts per packet and again on entry to the data segment.
    assign crc_clr = cmd_fire || ((st_d == ST_DAT) && (st_q != ST_DAT));
    assign crc_en  = (hdr_fire && (hdr_cnt >= HLEN_W'(skip_q))) || dat_fire;
    assign crc_din = (st_q == ST_HDR) ? hdr_byte : dat_byte;

    pci_crc8_acc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(crc_din), .crc(crc_val)
    );

    // Output byte mux and end-of-packet marking.
    always_comb begin
        out_valid = 1'b0;
        out_byte  = '0;
        out_last  = 1'b0;
        case (st_q)
            ST_HDR: begin
                out_valid = hdr_valid;
                out_byte  = hdr_byte;
                out_last  = hdr_last && !hcrc_q && (dlen_q == '0);
            end
            ST_HCRC: begin
                out_valid = 1'b1;
                out_byte  = crc_val;
                out_last  = (dlen_q == '0);
            end
            ST_DAT: begin
                out_valid = dat_valid;
                out_byte  = dat_byte;
                out_last  = dat_last && !dcrc_q;
            end
            ST_DCRC: begin
                out_valid = 1'b1;
                out_byte  = crc_val;
                out_last  = 1'b1;
            end
            default: ;
        endcase
    end

    pci_status u_sts (
        .clk(clk), .rst_n(rst_n), .start(cmd_fire),
        .busy((st_q != ST_IDLE) && (st_q != ST_DONE)),
        .done(st_q == ST_DONE), .link_err(link_err), .irq_en(irq_q),
        .sts_valid(sts_valid), .sts_sent(sts_sent),
        .sts_link_err(sts_link_err), .irq_pulse(irq_pulse)
    );
endmodule

// File: rtl/pkt_crc_inserter_chk.sv
// Module: port-level protocol checker for the CRC inserter, bound below.
module pkt_crc_inserter_chk (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_ready,
    input logic                       hdr_ready,
    input logic                       dat_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [pci_pkg::BYTE_W-1:0] out_byte,
    input logic                       out_last,
    input logic                       sts_valid,
    input logic                       sts_sent,
    input logic                       sts_link_err,
    input logic                       irq_pulse
);
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!out_valid && !sts_valid));

    p_seg_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ready && dat_ready));

    p_last_then_sts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> sts_valid);

    p_sts_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> (!sts_valid && cmd_ready));

    p_sts_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> (sts_sent != sts_link_err));

    p_irq_with_sts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> sts_valid);
endmodule

bind pkt_crc_inserter pkt_crc_inserter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .hdr_ready(hdr_ready),
    .dat_ready(dat_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .sts_valid(sts_valid),
    .sts_sent(sts_sent), .sts_link_err(sts_link_err), .irq_pulse(irq_pulse)
);

// File: tb/pkt_crc_inserter_tb_top.sv
// Bench: sweeps lengths, CRC options and skip counts with gaps and
// backpressure; expected streams are built arithmetically.
module pkt_crc_inserter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_hdr_len = '0;
    logic [15:0] cmd_dat_len = '0;
    logic        cmd_hcrc_en = 1'b0;
    logic        cmd_dcrc_en = 1'b0;
    logic [3:0]  cmd_skip = '0;
    logic        cmd_irq_en = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [7:0]  hdr_byte = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [7:0]  dat_byte = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_last;
    logic        link_err = 1'b0;
    logic        sts_valid, sts_sent, sts_link_err, irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] exp_b [0:63];
    int         exp_t [0:63];

    always #5 clk = ~clk;

    pkt_crc_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_hdr_len(cmd_hdr_len), .cmd_dat_len(cmd_dat_len),
        .cmd_hcrc_en(cmd_hcrc_en), .cmd_dcrc_en(cmd_dcrc_en),
        .cmd_skip(cmd_skip), .cmd_irq_en(cmd_irq_en),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_byte(hdr_byte),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last), .link_err(link_err), .sts_valid(sts_valid),
        .sts_sent(sts_sent), .sts_link_err(sts_link_err), .irq_pulse(irq_pulse)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 8'hE0;
        end
        return r;
    endfunction

    function automatic logic [7:0] hb(input int p, input int i);
        return 8'((p * 37 + i * 11 + 3) & 255);
    endfunction

    function automatic logic [7:0] db(input int p, input int i);
        return 8'((p * 53 + i * 29 + 101) & 255);
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic run_pkt(input int p, input int hl, input int dl, input bit hc,
                           input bit dc, input int sk, input bit ie,
                           input bit err_mid, input bit err_idle);
        int n, k, hi, di, guard;
        bit taken, busy_chk, done, hpend, dpend, exp_err;
        logic [7:0] c;
        n = 0;
        c = 8'h00;
        for (int i = 0; i < hl; i++) begin
            exp_b[n] = hb(p, i); exp_t[n] = 1; n++;
            if (i >= sk) c = ref_crc(c, hb(p, i));
        end
        if (hc && hl > 0) begin exp_b[n] = c; exp_t[n] = (sk > 0) ? 3 : 2; n++; end
        c = 8'h00;
        for (int i = 0; i < dl; i++) begin
            exp_b[n] = db(p, i); exp_t[n] = 1; n++;
            c = ref_crc(c, db(p, i));
        end
        if (dc && dl > 0) begin exp_b[n] = c; exp_t[n] = 4; n++; end
        exp_err = err_mid && (n > 0);

        // R7: link error while idle must not be recorded
        if (err_idle) begin
            @(negedge clk); link_err = 1'b1;
            @(negedge clk); link_err = 1'b0;
        end

        @(negedge clk);
        cmd_valid = 1'b1; cmd_hdr_len = 8'(hl); cmd_dat_len = 16'(dl);
        cmd_hcrc_en = hc; cmd_dcrc_en = dc; cmd_skip = 4'(sk); cmd_irq_en = ie;
        k = 0; hi = 0; di = 0; guard = 0;
        taken = 0; busy_chk = 0; done = 0; hpend = 0; dpend = 0;
        while (!done) begin
            if (guard > 0) @(negedge clk);
            guard++;
            cyc++;
            link_err = 1'b0;
            if (taken) cmd_valid = 1'b0;
            hdr_valid = taken && (hi < hl) && (hpend || (cyc % 3) != 2);
            hdr_byte  = hb(p, hi);
            dat_valid = taken && (di < dl) && (dpend || (cyc % 5) != 1);
            dat_byte  = db(p, di);
            out_ready = ((cyc + p) % 4) != 1;
            #1;
            if (busy_chk) begin
                chk(cmd_ready == 1'b0, "R9", cmd_ready, 0);
                busy_chk = 0;
            end
            if (cmd_valid && cmd_ready) begin taken = 1; busy_chk = 1; end
            hpend = hdr_valid && !hdr_ready;
            dpend = dat_valid && !dat_ready;
            if (hdr_valid && hdr_ready) hi++;
            if (dat_valid && dat_ready) di++;
            if (out_valid && out_ready) begin
                if (k < n) begin
                    chk(out_byte == exp_b[k], tag_name(exp_t[k]), out_byte, exp_b[k]);
                    chk(out_last == (k == n - 1), "R6", out_last, (k == n - 1));
                end else begin
                    chk(1'b0, "R5", k + 1, n);
                end
                k++;
                if (err_mid && k == 1) link_err = 1'b1;
            end
            if (sts_valid) begin
                chk(k == n, "R5", k, n);
                chk(sts_link_err == exp_err, "R7", sts_link_err, exp_err);
                chk(sts_sent == !exp_err, "R7", sts_sent, !exp_err);
                chk(irq_pulse == ie, "R8", irq_pulse, ie);
                done = 1;
            end
            if (guard > 300) begin
                chk(1'b0, "R7", 0, 1);
                done = 1;
            end
        end
        @(negedge clk);
        link_err = 1'b0; hdr_valid = 1'b0; dat_valid = 1'b0; cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        int sk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(cmd_ready == 1'b1, "R10", cmd_ready, 1);
        chk(out_valid == 1'b0, "R10", out_valid, 0);
        chk(hdr_ready == 1'b0 && dat_ready == 1'b0, "R10", {hdr_ready, dat_ready}, 0);
        chk(sts_valid == 1'b0 && irq_pulse == 1'b0, "R10", {sts_valid, irq_pulse}, 0);
        p = 0;
        for (int hl = 0; hl <= 4; hl++) begin
            for (int dl = 0; dl <= 3; dl++) begin
                for (int en = 0; en < 4; en++) begin
                    for (int si = 0; si < 5; si++) begin
                        case (si)
                            0: sk = 0;
                            1: sk = 1;
                            2: sk = 2;
                            3: sk = 5;
                            default: sk = 15;
                        endcase
                        run_pkt(p, hl, dl, en[0], en[1], sk, (p % 3) == 0,
                                (p % 7) == 3, (p % 7) == 5);
                        p++;
                    end
                end
            end
        end
        // R3: long header with skip 15 covering only the tail bytes
        run_pkt(p, 20, 2, 1'b1, 1'b1, 15, 1'b1, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule